// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches the already filtered samples of the two I2C bus lines and works out whether this device is the target of a transfer. It finds START and STOP conditions and keeps a bus-busy flag from them. After every START, including a repeated one, it shifts in the address byte or bytes and compares them with the device's own address. It then raises an acknowledge request for the ninth clock of each byte it answers, and it sets status flags that say whether the device was addressed, whether a general call was seen, and which transfer direction the master asked for.

The parameter `TEN_BIT` picks the addressing mode at build time. With seven-bit addressing one byte decides the match. With ten-bit addressing a write needs two bytes. A read is reached by a repeated START that follows a completed ten-bit write match. A general-call response can be switched on or off at run time. Shifting of data bytes and any host access are handled elsewhere. Once the address phase is over, this block ignores the bus until the next START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: `bus_busy` is 1 from the clock after a START (SDA goes 1 to 0 while SCL is 1 in both the previous and the current sample) until the clock after a STOP (SDA goes 0 to 1 under the same SCL condition). After reset it is 0. SDA changes while SCL is 0 leave it unchanged.
- R2: In seven-bit mode (`TEN_BIT`=0), a first byte after START whose bits 7:1 equal `own_addr7` sets `addr_hit` and loads `rw_flag` with bit 0 of that byte (1 = read, 0 = write). Bits arrive MSB first, each sampled on an SCL rising edge.
- R3: `ack_req` goes to 1 at the SCL falling edge that ends the eighth bit of a byte the block answers. It drops at the SCL falling edge that ends the ninth clock. It stays 0 for any byte the block does not answer.
- R4: In ten-bit mode, a first byte with bits 7:3 = 11110, bits 2:1 equal to `own_addr_hi[2:1]` and bit 0 = 0 is acknowledged but does not yet set `addr_hit`. A second byte equal to {`own_addr_hi[0]`, `own_addr7`} is acknowledged, sets `addr_hit` and clears `rw_flag`. Any other second byte is not acknowledged.
- R5: In ten-bit mode, a first byte that does not match the ten-bit prefix of the device and is not an enabled general call is neither acknowledged nor flagged.
- R6: In ten-bit mode, a first byte of 11110, `own_addr_hi[2:1]`, 1 is acknowledged and sets `addr_hit` with `rw_flag`=1 only if a full ten-bit write match happened earlier with no STOP since then. Otherwise it is ignored.
- R7: A first byte of 0x00 (general call, write) with `gc_enable`=1 sets `gcall_hit` and is acknowledged in both modes. With `gc_enable`=0 that byte gets no response. A general call takes precedence over an own-address match, so `addr_hit` and `gcall_hit` are never both 1.
- R8: A STOP or any START (repeated or not) clears `addr_hit` and `gcall_hit` on the following clock.
- R9: `addr_miss` is 1 whenever neither `addr_hit` nor `gcall_hit` is 1. This includes reset and the case of a START followed by a non-matching address.
- R10: After the address phase ends, further bytes are not acknowledged and leave all flags unchanged until the next START or STOP.
- R11: After reset, `ack_req`, `addr_hit`, `gcall_hit` and `bus_busy` are 0 and `addr_miss` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Filtered SDA sample |
| scl_in | input | 1 | Filtered SCL sample |
| own_addr7 | input | 7 | Seven-bit address, or the low seven bits of the ten-bit address |
| own_addr_hi | input | 3 | Upper three bits (9:7) of the ten-bit address |
| gc_enable | input | 1 | Answer the general-call address when 1 |
| bus_busy | output | 1 | Bus is between a START and a STOP |
| addr_hit | output | 1 | Device addressed by its own address |
| addr_miss | output | 1 | Device not addressed |
| gcall_hit | output | 1 | General call received while enabled |
| rw_flag | output | 1 | Direction bit captured with the matching address |
| ack_req | output | 1 | Request to drive an acknowledge on the ninth clock |

## Verification
A seven-bit and a ten-bit instance listen to the same bus. Every first-byte value from 0 to 255 is sent with general call disabled and again with it enabled. This separates own-address hits, reserved ten-bit prefixes, general calls and plain misses in both modes at once. A second sweep holds a valid ten-bit write prefix and walks all 256 second-byte values, so exactly one of them may match. While it runs, the seven-bit instance must ignore that second byte as data. Directed sequences cover a ten-bit read through a repeated START with and without an earlier write match, flags being cleared by a repeated START, and data bytes sent after a seven-bit match.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int unsigned BYTE_BITS = 8;
    localparam logic [4:0]  TEN_PREFIX = 5'b11110;
    localparam logic [7:0]  GCALL_BYTE = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_PRE_ACK,
        ST_ACK,
        ST_DATA
    } am_state_e;

    typedef struct packed {
        logic ack;   // answer this byte
        logic own;   // full own-address match
        logic gc;    // enabled general call
        logic rw;    // direction bit of the byte
        logic more;  // ten-bit prefix write, second byte follows
    } am_verdict_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic fall;
    } am_events_t;

    function automatic am_verdict_t judge_first(
        input logic [7:0] b,
        input logic       ten_mode,
        input logic [6:0] own7,
        input logic [2:0] own_hi,
        input logic       gc_en,
        input logic       ten_hit
    );
        am_verdict_t v;
        logic        pfx;
        v.gc   = gc_en && (b == GCALL_BYTE);
        v.rw   = b[0];
        pfx    = (b[7:3] == TEN_PREFIX) && (b[2:1] == own_hi[2:1]);
        if (ten_mode) begin
            v.own  = !v.gc && pfx && b[0] && ten_hit;
            v.more = !v.gc && pfx && !b[0];
        end else begin
            v.own  = !v.gc && (b[7:1] == own7);
            v.more = 1'b0;
        end
        v.ack = v.gc || v.own || v.more;
        return v;
    endfunction

    function automatic logic judge_second(
        input logic [7:0] b,
        input logic [6:0] own7,
        input logic [2:0] own_hi
    );
        return b == {own_hi[0], own7};
    endfunction

endpackage

// File: rtl/i2c_am_line_watch.sv
module i2c_am_line_watch
    import i2c_am_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_in,
    input  logic       scl_in,
    output am_events_t ev,
    output logic       scl_rise,
    output logic       busy
);
    logic sda_q, scl_q;
    logic scl_both_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda_in;
            scl_q <= scl_in;
        end
    end

    always_comb begin
        scl_both_high = scl_in && scl_q;
        ev.start      = scl_both_high && sda_q && !sda_in;
        ev.stop       = scl_both_high && !sda_q && sda_in;
        ev.fall       = scl_q && !scl_in;
        scl_rise      = !scl_q && scl_in;
    end

    always_ff @(posedge clk) begin
        if (rst)           busy <= 1'b0;
        else if (ev.stop)  busy <= 1'b0;
        else if (ev.start) busy <= 1'b1;
    end
endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter
    import i2c_am_pkg::*;
#(
    parameter int unsigned NBITS = BYTE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             rise,
    input  logic             sda_in,
    output logic             done,
    output logic [NBITS-1:0] data
);
    localparam int unsigned CW = $clog2(NBITS + 1);
    localparam logic [CW-1:0] LAST = CW'(NBITS - 1);
    localparam logic [CW-1:0] FULL = CW'(NBITS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            data <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                cnt <= '0;
            end else if (rise && cnt != FULL) begin
                data <= {data[NBITS-2:0], sda_in};
                cnt  <= cnt + 1'b1;
                done <= (cnt == LAST);
            end
        end
    end
endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
    import i2c_am_pkg::*;
#(
    parameter bit TEN_BIT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  am_events_t ev,
    input  logic       done,
    input  logic [7:0] rx_byte,
    input  logic [6:0] own7,
    input  logic [2:0] own_hi,
    input  logic       gc_en,
    output logic       shift_clr,
    output logic       aas,
    output logic       abgc,
    output logic       naas,
    output logic       srw,
    output logic       ack_req
);
    am_state_e   state;
    am_verdict_t v1;
    logic        ack_pend;
    logic        more;
    logic        ten_hit;
    logic        hit2;

    always_comb begin
        v1        = judge_first(rx_byte, TEN_BIT, own7, own_hi, gc_en, ten_hit);
        hit2      = judge_second(rx_byte, own7, own_hi);
        shift_clr = ev.start || (state == ST_ACK && ev.fall);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            aas      <= 1'b0;
            abgc     <= 1'b0;
            naas     <= 1'b1;
            srw      <= 1'b0;
            ack_req  <= 1'b0;
            ack_pend <= 1'b0;
            more     <= 1'b0;
            ten_hit  <= 1'b0;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            aas     <= 1'b0;
            abgc    <= 1'b0;
            naas    <= 1'b1;
            ack_req <= 1'b0;
            ten_hit <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_ADDR1;
            aas     <= 1'b0;
            abgc    <= 1'b0;
            naas    <= 1'b1;
            ack_req <= 1'b0;
        end else begin
            case (state)
                ST_ADDR1: if (done) begin
                    if (v1.gc) begin
                        abgc <= 1'b1;
                        naas <= 1'b0;
                        srw  <= 1'b0;
                    end
                    if (v1.own) begin
                        aas  <= 1'b1;
                        naas <= 1'b0;
                        srw  <= v1.rw;
                    end
                    if (!v1.own) ten_hit <= 1'b0;
                    ack_pend <= v1.ack;
                    more     <= v1.more;
                    state    <= ST_PRE_ACK;
                end
                ST_ADDR2: if (done) begin
                    if (hit2) begin
                        aas  <= 1'b1;
                        naas <= 1'b0;
                        srw  <= 1'b0;
                    end
                    ten_hit  <= hit2;
                    ack_pend <= hit2;
                    more     <= 1'b0;
                    state    <= ST_PRE_ACK;
                end
                ST_PRE_ACK: if (ev.fall) begin
                    ack_req <= ack_pend;
                    state   <= ST_ACK;
                end
                ST_ACK: if (ev.fall) begin
                    ack_req <= 1'b0;
                    state   <= more ? ST_ADDR2 : ST_DATA;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter bit TEN_BIT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_in,
    input  logic       scl_in,
    input  logic [6:0] own_addr7,
    input  logic [2:0] own_addr_hi,
    input  logic       gc_enable,
    output logic       bus_busy,
    output logic       addr_hit,
    output logic       addr_miss,
    output logic       gcall_hit,
    output logic       rw_flag,
    output logic       ack_req
);
    am_events_t ev;
    logic       scl_rise;
    logic       shift_clr;
    logic       byte_done;
    logic [7:0] rx_byte;

    i2c_am_line_watch u_watch (
        .clk      (clk),
        .rst      (rst),
        .sda_in   (sda_in),
        .scl_in   (scl_in),
        .ev       (ev),
        .scl_rise (scl_rise),
        .busy     (bus_busy)
    );

    i2c_am_shifter #(.NBITS(BYTE_BITS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr    (shift_clr),
        .rise   (scl_rise),
        .sda_in (sda_in),
        .done   (byte_done),
        .data   (rx_byte)
    );

    i2c_am_fsm #(.TEN_BIT(TEN_BIT)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .done      (byte_done),
        .rx_byte   (rx_byte),
        .own7      (own_addr7),
        .own_hi    (own_addr_hi),
        .gc_en     (gc_enable),
        .shift_clr (shift_clr),
        .aas       (addr_hit),
        .abgc      (gcall_hit),
        .naas      (addr_miss),
        .srw       (rw_flag),
        .ack_req   (ack_req)
    );
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
    input logic clk,
    input logic rst,
    input logic sda_in,
    input logic scl_in,
    input logic bus_busy,
    input logic addr_hit,
    input logic addr_miss,
    input logic gcall_hit,
    input logic ack_req
);
    logic [1:0] hist;
    logic       ok;

    always_ff @(posedge clk) begin
        if (rst)              hist <= 2'd0;
        else if (hist != 2'd2) hist <= hist + 2'd1;
    end
    assign ok = (hist == 2'd2);

    // R1
    a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (ok && scl_in && $past(scl_in) && $past(sda_in) && !sda_in) |=> bus_busy);

    // R1, R8
    a_r1_stop_clears: assert property (@(posedge clk) disable iff (rst)
        (ok && scl_in && $past(scl_in) && !$past(sda_in) && sda_in)
        |=> (!bus_busy && !addr_hit && !gcall_hit));

    // R8
    a_r8_start_clears_hit: assert property (@(posedge clk) disable iff (rst)
        (ok && scl_in && $past(scl_in) && $past(sda_in) && !sda_in)
        |=> (!addr_hit && !gcall_hit));

    // R9
    a_r9_miss_complement: assert property (@(posedge clk) disable iff (rst)
        addr_miss == !(addr_hit || gcall_hit));

    // R7
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(addr_hit && gcall_hit));

    // R3
    a_r3_ack_on_fall: assert property (@(posedge clk) disable iff (rst)
        (ok && $rose(ack_req)) |-> (!$past(scl_in) && $past(scl_in, 2)));

    // R3
    a_r3_ack_needs_busy: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> bus_busy);
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_in    (sda_in),
    .scl_in    (scl_in),
    .bus_busy  (bus_busy),
    .addr_hit  (addr_hit),
    .addr_miss (addr_miss),
    .gcall_hit (gcall_hit),
    .ack_req   (ack_req)
);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
    localparam int Q = 2;
    localparam logic [6:0] OWN7 = 7'h2C;
    localparam logic [2:0] OWNHI = 3'b101;
    localparam logic [7:0] PFX_W = 8'hF4;
    localparam logic [7:0] PFX_R = 8'hF5;
    localparam logic [7:0] LOW2  = 8'hAC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sda = 1'b1;
    logic scl = 1'b1;
    logic gc_en = 1'b0;

    logic bb7, hit7, miss7, gc7, rw7, ack7;
    logic bb10, hit10, miss10, gc10, rw10, ack10;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_addr_match #(.TEN_BIT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .sda_in(sda), .scl_in(scl),
        .own_addr7(OWN7), .own_addr_hi(OWNHI), .gc_enable(gc_en),
        .bus_busy(bb7), .addr_hit(hit7), .addr_miss(miss7),
        .gcall_hit(gc7), .rw_flag(rw7), .ack_req(ack7));

    i2c_addr_match #(.TEN_BIT(1'b1)) u_dut10 (
        .clk(clk), .rst(rst), .sda_in(sda), .scl_in(scl),
        .own_addr7(OWN7), .own_addr_hi(OWNHI), .gc_enable(gc_en),
        .bus_busy(bb10), .addr_hit(hit10), .addr_miss(miss10),
        .gcall_hit(gc10), .rw_flag(rw10), .ack_req(ack10));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda = b[i]; tick(Q);
            scl = 1'b1; tick(2 * Q);
            scl = 1'b0; tick(Q);
        end
    endtask

    // ninth clock: checks ack_req of both instances while SCL low and high
    task automatic ack_clock(input string tag, input logic e7, input logic e10);
        sda = 1'b1; tick(1);
        chk({tag, " R3 ack7 low"}, ack7, e7);
        chk({tag, " R3 ack10 low"}, ack10, e10);
        tick(Q - 1);
        scl = 1'b1; tick(Q);
        chk({tag, " R3 ack7 high"}, ack7, e7);
        chk({tag, " R3 ack10 high"}, ack10, e10);
        tick(Q);
        scl = 1'b0; tick(Q);
        chk({tag, " R3 ack7 released"}, ack7, 1'b0);
        chk({tag, " R3 ack10 released"}, ack10, 1'b0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : main
        logic e_gc, e_own7, e_pfx;
        tick(4);
        rst = 1'b0;
        tick(2);
        // R11 reset state
        chk("R11 busy7", bb7, 1'b0);
        chk("R11 busy10", bb10, 1'b0);
        chk("R11 hit7", hit7, 1'b0);
        chk("R11 gc7", gc7, 1'b0);
        chk("R11 miss7", miss7, 1'b1);
        chk("R11 miss10", miss10, 1'b1);
        chk("R11 ack7", ack7, 1'b0);

        // Sweep 1: every first byte, general call off then on (R2 R5 R7 R9)
        for (int g = 0; g < 2; g++) begin
            gc_en = g[0];
            for (int b = 0; b < 256; b++) begin
                e_gc   = (g == 1) && (b == 0);
                e_own7 = !e_gc && (b[7:1] == OWN7);
                e_pfx  = !e_gc && (b[7:3] == 5'b11110) && (b[2:1] == OWNHI[2:1]) && !b[0];
                bus_start();
                chk("R1 busy after start", bb7, 1'b1);
                send_byte(8'(b));
                ack_clock("sweep1", e_gc || e_own7, e_gc || e_pfx);
                chk("R2 hit7", hit7, e_own7);
                chk("R7 gc7", gc7, e_gc);
                chk("R9 miss7", miss7, !(e_gc || e_own7));
                chk("R5 hit10", hit10, 1'b0);
                chk("R7 gc10", gc10, e_gc);
                chk("R9 miss10", miss10, !e_gc);
                if (e_own7) chk("R2 rw7", rw7, b[0]);
                bus_stop();
                chk("R1 busy after stop", bb10, 1'b0);
                chk("R8 hit7 after stop", hit7, 1'b0);
                chk("R8 gc10 after stop", gc10, 1'b0);
            end
        end
        gc_en = 1'b0;

        // Sweep 2: ten-bit second byte (R4), seven-bit ignores it (R10)
        for (int c = 0; c < 256; c++) begin
            bus_start();
            send_byte(PFX_W);
            ack_clock("sweep2 first", 1'b0, 1'b1);
            chk("R4 no hit after prefix", hit10, 1'b0);
            send_byte(8'(c));
            ack_clock("sweep2 second", 1'b0, c == LOW2);
            chk("R4 hit10", hit10, c == LOW2);
            if (c == LOW2) chk("R4 rw10", rw10, 1'b0);
            chk("R10 hit7 held", hit7, 1'b0);
            bus_stop();
        end

        // R6: ten-bit read via repeated START after a write match
        bus_start();
        send_byte(PFX_W);
        ack_clock("R6 w1", 1'b0, 1'b1);
        send_byte(LOW2);
        ack_clock("R6 w2", 1'b0, 1'b1);
        chk("R6 hit10 after write", hit10, 1'b1);
        bus_rstart();
        chk("R8 hit10 cleared by restart", hit10, 1'b0);
        chk("R1 busy through restart", bb10, 1'b1);
        send_byte(PFX_R);
        ack_clock("R6 read", 1'b0, 1'b1);
        chk("R6 hit10 read", hit10, 1'b1);
        chk("R6 rw10 read", rw10, 1'b1);
        bus_stop();
        // R6: read prefix without earlier write match is ignored
        bus_start();
        send_byte(PFX_R);
        ack_clock("R6 cold read", 1'b0, 1'b0);
        chk("R6 cold hit10", hit10, 1'b0);
        bus_stop();

        // R8, R10: seven-bit read match, data byte ignored, restart clears
        bus_start();
        send_byte({OWN7, 1'b1});
        ack_clock("R2 read", 1'b1, 1'b0);
        chk("R2 hit7 read", hit7, 1'b1);
        chk("R2 rw7 read", rw7, 1'b1);
        send_byte({OWN7, 1'b0});
        ack_clock("R10 data", 1'b0, 1'b0);
        chk("R10 hit7 held", hit7, 1'b1);
        chk("R10 rw7 held", rw7, 1'b1);
        bus_rstart();
        chk("R8 hit7 cleared by restart", hit7, 1'b0);
        chk("R9 miss7 after restart", miss7, 1'b1);
        send_byte(8'h12);
        ack_clock("R9 nomatch", 1'b0, 1'b0);
        chk("R9 miss7 nomatch", miss7, 1'b1);
        bus_stop();

        // R1: SDA toggles with SCL low do not change busy
        scl = 1'b0; tick(Q);
        sda = 1'b0; tick(Q);
        sda = 1'b1; tick(Q);
        chk("R1 busy idle toggles", bb7, 1'b0);
        scl = 1'b1; tick(Q);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule